// File: doc/BRIEF.md
# Power Mode and Wake-up Controller

This block manages the clocks of a small microcontroller. It holds a five-bit control register that software writes. From that register, a CPU stop strobe, eight active-low external interrupt lines with per-line wake enables, and one internal interrupt, it produces a CPU clock enable, a peripheral clock enable, an oscillator enable, a level-7 wake interrupt request and a bus pull-up enable. All outputs are registered. The clock enables drive clock-enable gating on the full-rate clock.

There are three low-power states. In power-down, entered by arming a bit and then issuing a stop, the oscillator enable drops and every clock stops. In standby, only the CPU clock stops while peripherals keep running. In slow mode, both clocks run at 1/512 of the input rate. A wake from power-down normally waits a fixed oscillator settle time. A bypass bit lets the clocks restart at once. The internal reset is the synchronous `rst` input. The controller is assumed to sit on an always-on clock, so the wake logic keeps running while `osc_en` is low.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, `cpu_clk_en`, `per_clk_en` and `osc_en` are 1, `wake_irq7` is 0 and `ctrl_q` is 0. Control bits: [0] power-down arm, [1] standby, [2] slow, [3] fast wake, [4] pull-up.
- R2: Power-down is entered only when `stop_strobe` is seen while running with bit 0 already set. From the next cycle `osc_en`, `cpu_clk_en` and `per_clk_en` are 0. Register writes are ignored unless the controller is running.
- R3: Power-down is left when any line i of `ext_irq_n[7:0]` is low while `wake_en[i]` is 1. Line 7 is the non-maskable one. A low line whose enable is 0 has no effect.
- R4: On wake with bit 3 clear, `osc_en` rises at once, and both clock enables stay 0 for exactly WAKE_DELAY (1536) cycles after that. With bit 3 set, the clocks return in the same cycle as `osc_en`.
- R5: Hardware clears control bit 0 at the wake edge.
- R6: `wake_irq7` goes to 1 in the cycle the clocks are released after a wake from power-down. It stays at 1 until `irq_ack` is seen.
- R7: While bit 1 is set, `cpu_clk_en` is 0 and `per_clk_en` keeps running. While running, `int_irq` or any enabled low external line clears bit 1. A low line whose enable is 0 does not clear it.
- R8: While bit 2 is in effect, each clock enable is 1 for one cycle in every 512. A change of bit 2 takes effect only at the wrap of the 9-bit divider, so no short enable run appears. Clearing bit 2 returns both clocks to full rate.
- R9: When power-down is entered from slow mode, bit 2 stays set, and the controller resumes in slow mode after the wake.
- R10: `pullup_en` follows control bit 4.
- R11: With the default STOP_HALTS=1, a stop strobe seen while running with bit 0 clear sets bit 1 (standby). With STOP_HALTS=0 the strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst | input | 1 | Synchronous active-high internal reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 5 | Control register write data |
| stop_strobe | input | 1 | CPU stop instruction pulse |
| ext_irq_n | input | 8 | External interrupt lines, active low (7 is non-maskable) |
| wake_en | input | 8 | Per-line wake enables |
| int_irq | input | 1 | Internal interrupt pending |
| irq_ack | input | 1 | CPU acknowledge of the wake interrupt |
| ctrl_q | output | 5 | Current control register contents |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| wake_irq7 | output | 1 | Level-7 wake interrupt request |
| pullup_en | output | 1 | Address/data bus pull-up enable |

## Verification
The bench targets the exact length of the settle window. A counter that is off by one would release the clocks one cycle early or late, and the comparison against the model would mismatch on that edge. It drives low wake lines whose enable is clear, both in power-down and in standby. A design that ignored the enables would leave these states when it should not. It also writes the register during power-down, which a design without the running guard would accept. Slow-mode pulses are counted across entry, exit and a power-down taken in slow mode. A divider that switched rate off its wrap would give extra pulses, and a divider that lost the slow bit on wake would come back at full rate.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {ST_RUN = 2'd0, ST_DOWN = 2'd1, ST_SETTLE = 2'd2} pm_state_e;

  localparam int CTRL_W  = 5;
  localparam int CB_PDN  = 0;
  localparam int CB_HOLD = 1;
  localparam int CB_SLOW = 2;
  localparam int CB_FAST = 3;
  localparam int CB_PULL = 4;
endpackage

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
  import pmc_pkg::*;
#(
  parameter int STOP_HALTS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              running,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              stop,
  input  logic              irq_evt,
  input  logic              pdn_clr,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CTRL_W-1:0] ctrl_d
);
  logic halt_set;

  generate
    if (STOP_HALTS != 0) begin : g_stop_halts
      assign halt_set = running & stop & ~ctrl_q[CB_PDN];
    end else begin : g_stop_ignored
      assign halt_set = 1'b0;
    end
  endgenerate

  always_comb begin
    ctrl_d = ctrl_q;
    if (we && running) ctrl_d = wdata;
    if (halt_set) ctrl_d[CB_HOLD] = 1'b1;
    if (running && irq_evt) ctrl_d[CB_HOLD] = 1'b0;
    if (pdn_clr) ctrl_d[CB_PDN] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_d;
  end

  // R5
  pdn_auto_clear_chk: assert property (@(posedge clk) disable iff (rst)
    pdn_clr |=> !ctrl_q[CB_PDN]);

  // R2
  write_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (!running && !pdn_clr) |=> (ctrl_q == $past(ctrl_q)));
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
#(
  parameter int WAKE_DELAY = 1536
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      stop,
  input  logic      pdn_armed,
  input  logic      fast_wake,
  input  logic      wake_evt,
  output pm_state_e state_q,
  output pm_state_e state_d,
  output logic      release_now
);
  localparam int CNT_W = $clog2(WAKE_DELAY);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_DELAY - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    release_now = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (stop && pdn_armed) begin
          state_d = ST_DOWN;
          cnt_d   = '0;
        end
      end
      ST_DOWN: begin
        if (wake_evt) begin
          cnt_d = '0;
          if (fast_wake) begin
            state_d     = ST_RUN;
            release_now = 1'b1;
          end else begin
            state_d = ST_SETTLE;
          end
        end
      end
      ST_SETTLE: begin
        if (cnt_q == CNT_LAST) begin
          state_d     = ST_RUN;
          release_now = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // R4
  settle_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SETTLE) |-> (cnt_q <= CNT_LAST));

  // R3
  down_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DOWN && !wake_evt) |=> (state_q == ST_DOWN));
endmodule

// File: rtl/pmc_clkdiv.sv
module pmc_clkdiv #(
  parameter int DIV_W = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic freeze,
  input  logic slow_req,
  output logic wrap,
  output logic slow_eff
);
  logic [DIV_W-1:0] div_q;

  assign wrap = (&div_q) & ~freeze;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q    <= '0;
      slow_eff <= 1'b0;
    end else if (!freeze) begin
      div_q <= div_q + 1'b1;
      if (wrap) slow_eff <= slow_req;
    end
  end

  // R8
  switch_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (slow_eff != $past(slow_eff)) |-> (div_q == '0));

  // R9
  frozen_div_chk: assert property (@(posedge clk) disable iff (rst)
    $past(freeze) |-> (div_q == $past(div_q)));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int N_IRQ      = 8,
  parameter int WAKE_DELAY = 1536,
  parameter int DIV_W      = 9,
  parameter int STOP_HALTS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic              stop_strobe,
  input  logic [N_IRQ-1:0]  ext_irq_n,
  input  logic [N_IRQ-1:0]  wake_en,
  input  logic              int_irq,
  input  logic              irq_ack,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              osc_en,
  output logic              wake_irq7,
  output logic              pullup_en
);
  pm_state_e         state_q, state_d;
  logic [CTRL_W-1:0] ctrl_d;
  logic              wake_evt, release_now, running, wrap, slow_eff, gate;

  assign wake_evt = |(~ext_irq_n & wake_en);
  assign running  = (state_q == ST_RUN);

  pmc_ctrl_reg #(.STOP_HALTS(STOP_HALTS)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .running (running),
    .we      (cfg_we),
    .wdata   (cfg_wdata),
    .stop    (stop_strobe),
    .irq_evt (int_irq | wake_evt),
    .pdn_clr ((state_q == ST_DOWN) & wake_evt),
    .ctrl_q  (ctrl_q),
    .ctrl_d  (ctrl_d)
  );

  pmc_fsm #(.WAKE_DELAY(WAKE_DELAY)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .stop        (stop_strobe),
    .pdn_armed   (ctrl_q[CB_PDN]),
    .fast_wake   (ctrl_q[CB_FAST]),
    .wake_evt    (wake_evt),
    .state_q     (state_q),
    .state_d     (state_d),
    .release_now (release_now)
  );

  pmc_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .freeze   (state_q == ST_DOWN),
    .slow_req (ctrl_q[CB_SLOW]),
    .wrap     (wrap),
    .slow_eff (slow_eff)
  );

  assign gate      = slow_eff ? wrap : 1'b1;
  assign pullup_en = ctrl_q[CB_PULL];

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en <= 1'b1;
      per_clk_en <= 1'b1;
      osc_en     <= 1'b1;
      wake_irq7  <= 1'b0;
    end else begin
      per_clk_en <= (state_d == ST_RUN) & gate;
      cpu_clk_en <= (state_d == ST_RUN) & gate & ~ctrl_d[CB_HOLD];
      osc_en     <= (state_d != ST_DOWN);
      if (release_now)  wake_irq7 <= 1'b1;
      else if (irq_ack) wake_irq7 <= 1'b0;
    end
  end

  // R2
  frozen_clocks_chk: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> (!cpu_clk_en && !per_clk_en));

  // R2
  pd_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (running && stop_strobe && ctrl_q[CB_PDN]) |=> !osc_en);

  // R6
  irq_after_wake_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_irq7) |-> ($past(state_q) != ST_RUN));

  // R7
  standby_cpu_off_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[CB_HOLD] |-> !cpu_clk_en);

  // R8
  slow_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (slow_eff && per_clk_en) |=> !per_clk_en);
endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  localparam int DLY = 1536;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic       stop_strobe = 1'b0;
  logic [7:0] ext_irq_n = 8'hFF;
  logic [7:0] wake_en = 8'h00;
  logic       int_irq = 1'b0;
  logic       irq_ack = 1'b0;
  logic [4:0] ctrl_q;
  logic       cpu_clk_en, per_clk_en, osc_en, wake_irq7, pullup_en;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_mode_ctrl u_pwr_mode_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .stop_strobe(stop_strobe), .ext_irq_n(ext_irq_n), .wake_en(wake_en),
    .int_irq(int_irq), .irq_ack(irq_ack), .ctrl_q(ctrl_q),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .wake_irq7(wake_irq7), .pullup_en(pullup_en)
  );

  // behavioural reference: 0 run, 1 down, 2 settle
  int       m_state, m_cnt, m_div, ns;
  bit       m_slow_eff, m_cpu, m_per, m_osc, m_irq, wk, gate, rel;
  bit [4:0] m_ctrl, nctrl;

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_cnt = 0; m_div = 0; m_slow_eff = 0; m_ctrl = 0;
      m_cpu = 1; m_per = 1; m_osc = 1; m_irq = 0;
    end else begin
      wk = 0;
      for (int i = 0; i < 8; i++) if (!ext_irq_n[i] && wake_en[i]) wk = 1;
      ns = m_state; rel = 0;
      if (m_state == 0) begin
        if (stop_strobe && m_ctrl[0]) begin ns = 1; m_cnt = 0; end
      end else if (m_state == 1) begin
        if (wk) begin
          m_cnt = 0;
          if (m_ctrl[3]) begin ns = 0; rel = 1; end else ns = 2;
        end
      end else begin
        if (m_cnt == DLY - 1) begin ns = 0; rel = 1; end else m_cnt++;
      end
      nctrl = m_ctrl;
      if (cfg_we && m_state == 0) nctrl = cfg_wdata;
      if (m_state == 0 && stop_strobe && !m_ctrl[0]) nctrl[1] = 1;
      if (m_state == 0 && (int_irq || wk)) nctrl[1] = 0;
      if (m_state == 1 && wk) nctrl[0] = 0;
      gate = m_slow_eff ? (m_state != 1 && m_div == 511) : 1'b1;
      if (m_state != 1) begin
        if (m_div == 511) begin m_div = 0; m_slow_eff = m_ctrl[2]; end
        else m_div++;
      end
      m_per = (ns == 0) && gate;
      m_cpu = m_per && !nctrl[1];
      m_osc = (ns != 1);
      if (rel) m_irq = 1; else if (irq_ack) m_irq = 0;
      m_ctrl = nctrl; m_state = ns;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk("R4 osc_en vs model", int'(osc_en), int'(m_osc));
      chk("R7 cpu_clk_en vs model", int'(cpu_clk_en), int'(m_cpu));
      chk("R8 per_clk_en vs model", int'(per_clk_en), int'(m_per));
      chk("R6 wake_irq7 vs model", int'(wake_irq7), int'(m_irq));
      chk("R5 ctrl_q vs model", int'(ctrl_q), int'(m_ctrl));
      chk("R10 pullup_en vs model", int'(pullup_en), int'(m_ctrl[4]));
    end
  end

  task automatic wr(input logic [4:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic stop_pulse();
    @(negedge clk); stop_strobe = 1;
    @(negedge clk); stop_strobe = 0;
  endtask

  task automatic line_pulse(input int ln);
    @(negedge clk); ext_irq_n[ln] = 1'b0;
    @(negedge clk); ext_irq_n[ln] = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_pulses(input int n, output int c);
    c = 0;
    repeat (n) begin @(negedge clk); if (per_clk_en) c++; end
  endtask

  initial begin
    int c, settle;
    repeat (4) @(negedge clk);
    rst = 0;
    cmp_on = 1;
    // r1_reset
    chk("R1 reset cpu_clk_en", int'(cpu_clk_en), 1);
    chk("R1 reset osc_en", int'(osc_en), 1);
    chk("R1 reset ctrl_q", int'(ctrl_q), 0);
    chk("R1 reset wake_irq7", int'(wake_irq7), 0);

    wr(5'b10000);
    chk("R10 pullup on", int'(pullup_en), 1);
    wr(5'b00010);
    chk("R7 standby cpu off", int'(cpu_clk_en), 0);
    chk("R7 standby per on", int'(per_clk_en), 1);
    @(negedge clk); int_irq = 1; @(negedge clk); int_irq = 0;
    chk("R7 int_irq clears standby", int'(ctrl_q[1]), 0);

    stop_pulse();
    chk("R11 stop without arm -> standby", int'(ctrl_q[1]), 1);
    wake_en = 8'h04;
    line_pulse(3);
    chk("R7 disabled line keeps standby", int'(ctrl_q[1]), 1);
    line_pulse(2);
    chk("R7 enabled line clears standby", int'(ctrl_q[1]), 0);
    chk("R7 cpu back", int'(cpu_clk_en), 1);

    wr(5'b00001);
    stop_pulse();
    chk("R2 power-down osc off", int'(osc_en), 0);
    chk("R2 power-down cpu off", int'(cpu_clk_en), 0);
    chk("R2 power-down per off", int'(per_clk_en), 0);
    wr(5'b10000);
    chk("R2 write ignored in power-down", int'(ctrl_q), 1);
    wake_en = 8'h80;
    line_pulse(1);
    idle(20);
    chk("R3 disabled line no wake", int'(osc_en), 0);
    @(negedge clk); ext_irq_n[7] = 1'b0;
    @(negedge clk); ext_irq_n[7] = 1'b1;
    chk("R5 arm bit cleared at wake", int'(ctrl_q[0]), 0);
    settle = 0;
    while (osc_en && !cpu_clk_en && settle < 5000) begin settle++; @(negedge clk); end
    chk("R4 settle length", settle, DLY);
    chk("R6 wake irq raised", int'(wake_irq7), 1);
    idle(3);
    chk("R6 wake irq held", int'(wake_irq7), 1);
    @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
    chk("R6 wake irq acked", int'(wake_irq7), 0);

    wr(5'b01001);
    stop_pulse();
    wake_en = 8'h01;
    @(negedge clk); ext_irq_n[0] = 1'b0;
    @(negedge clk); ext_irq_n[0] = 1'b1;
    chk("R4 fast wake immediate cpu", int'(cpu_clk_en), 1);
    chk("R4 fast wake osc", int'(osc_en), 1);

    wr(5'b00100);
    idle(1100);
    count_pulses(1024, c);
    chk("R8 slow pulses per 1024", c, 2);
    wr(5'b01101);
    stop_pulse();
    idle(37);
    line_pulse(0);
    chk("R9 slow bit kept", int'(ctrl_q), 5'b01100);
    idle(600);
    count_pulses(1024, c);
    chk("R9 slow after wake", c, 2);
    wr(5'b00000);
    idle(600);
    count_pulses(100, c);
    chk("R8 full rate restored", c, 100);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired R1..");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule